// File: doc/BRIEF.md
# Variable Shift and Rotate Execute Unit

This unit takes one 32-bit instruction word and recognises the register-controlled shift and rotate group of a 64-bit integer instruction set. When the word belongs to that group, the unit sets two register-file read indices straight from the word's fields. It receives the source operand and the amount operand back in the same cycle. It then computes a logical left shift, a logical right shift, an arithmetic right shift or a rotate right, on either 32 or 64 bits.

One clock after the valid strobe, it presents a registered write enable, a destination index and the result for the register file. Any word outside the group raises a no-match flag, so that another decoder can take it.

Register index 31 works as a zero register. Reading it yields zero for either operand, and a write aimed at it is dropped. The amount comes from a full 64-bit register, and only its low bits are used, so large amounts wrap around the operand width.

Top module: `varShiftUnit`

## Requirements
- R1: A word belongs to the group only when bits 15:12 equal 0010 and bits 30:21 equal 0011010110. For any other word with the valid strobe, the next cycle shows noMatch high and wrEn low.
- R2: srcIdx equals word bits 9:5 and amtIdx equals word bits 20:16 in the same cycle, with no register on the way. For a matching word, wrIdx on the next cycle equals bits 4:0.
- R3: Bits 11:10 pick the operation: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R4: When bit 31 is 1, the operation uses all 64 bits. When it is 0, only the low 32 bits of the source are used, and the 32-bit result is zero-extended to 64 bits.
- R5: The amount is the amount operand ANDed with 63 in 64-bit mode and with 31 in 32-bit mode.
- R6: The arithmetic right shift fills vacated positions with source bit 63 in 64-bit mode and with source bit 31 in 32-bit mode.
- R7: For a nonzero amount n in width W, rotate right gives (src >> n) | (src << (W - n)).
- R8: A rotate with an amount of zero (after masking) returns the source unchanged, zero-extended in 32-bit mode.
- R9: Index 31 reads as zero for both the source and the amount operand, whatever the register file returns.
- R10: A matching word with destination 31 gives outValid high and wrEn low.
- R11: outValid, wrEn, wrIdx, wrData and noMatch appear exactly one clock after a valid strobe. outValid is low in a cycle that follows no strobe.
- R12: A synchronous active-high reset clears outValid, wrEn and noMatch on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| srcIdx | output | 5 | Read index for the source operand |
| amtIdx | output | 5 | Read index for the amount operand |
| srcData | input | 64 | Register file value at srcIdx |
| amtData | input | 64 | Register file value at amtIdx |
| outValid | output | 1 | A strobed word was handled last cycle |
| wrEn | output | 1 | Write the result to the register file |
| wrIdx | output | 5 | Destination register index |
| wrData | output | 64 | Result to write |
| noMatch | output | 1 | Last strobed word is not in this group |

## Verification
The read indices are combinational, so they are checked in the same cycle as the word, shortly after it is driven. All other results come from one register stage. The bench drives each word on a falling edge and checks outValid, wrEn, wrIdx, wrData and noMatch on the next falling edge, half a period after the capturing rising edge. It then checks outValid again one cycle later, with no strobe, to confirm that nothing arrives late.

// File: rtl/varShiftPkg.sv
package varShiftPkg;

  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_ROR = 2'b11
  } shiftOp_e;

  localparam logic [9:0] GROUP_HI  = 10'b0011010110;
  localparam logic [3:0] GROUP_MID = 4'b0010;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic       fire;
    logic       match;
    logic       wide;
    shiftOp_e   op;
    logic       srcIsZero;
    logic       amtIsZero;
    logic       dstWritable;
    logic [4:0] dstIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/shiftLane.sv
module shiftLane
  import varShiftPkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]         srcVal,
  input  logic [$clog2(W)-1:0] amt,
  input  shiftOp_e             op,
  output logic [W-1:0]         res
);
  localparam int AW = $clog2(W);
  localparam logic [AW:0] FULL = (AW+1)'(W);

  logic [AW:0]  backAmt;
  logic [W-1:0] asrVal;

  assign backAmt = FULL - {1'b0, amt};
  assign asrVal  = $signed(srcVal) >>> amt;

  always_comb begin
    unique case (op)
      OP_LSL:  res = srcVal << amt;
      OP_LSR:  res = srcVal >> amt;
      OP_ASR:  res = asrVal;
      OP_ROR:  res = (amt == '0) ? srcVal
                                 : ((srcVal >> amt) | (srcVal << backAmt));
      default: res = srcVal;
    endcase
  end
endmodule

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import varShiftPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             inValid,
  input  logic [31:0]      instrWord,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] amtIdx,
  output ctrlStrobe_t      ctrl
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  logic [IDX_W-1:0] dstIdx;

  assign srcIdx = instrWord[9:5];
  assign amtIdx = instrWord[20:16];
  assign dstIdx = instrWord[4:0];

  always_comb begin
    ctrl.fire        = inValid;
    ctrl.match       = (instrWord[30:21] == GROUP_HI) &&
                       (instrWord[15:12] == GROUP_MID);
    ctrl.wide        = instrWord[31];
    ctrl.op          = shiftOp_e'(instrWord[11:10]);
    ctrl.srcIsZero   = (srcIdx == ZERO_IDX);
    ctrl.amtIsZero   = (amtIdx == ZERO_IDX);
    ctrl.dstWritable = (dstIdx != ZERO_IDX);
    ctrl.dstIdx      = dstIdx;
  end
endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import varShiftPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       ctrl,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] amtData,
  output logic              outValid,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              noMatch
);
  localparam int HALF_W = DATA_W / 2;
  localparam int AMT_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] srcOp;
  logic [DATA_W-1:0] amtOp;
  logic [DATA_W-1:0] wideRes;
  logic [HALF_W-1:0] narrowRes;
  logic [DATA_W-1:0] result;
  logic              unusedAmtHigh;

  // zero-register convention on both operands
  assign srcOp = ctrl.srcIsZero ? '0 : srcData;
  assign amtOp = ctrl.amtIsZero ? '0 : amtData;
  assign unusedAmtHigh = ^amtOp[DATA_W-1:AMT_W];

  shiftLane #(.W(DATA_W)) wideLane (
    .srcVal (srcOp),
    .amt    (amtOp[AMT_W-1:0]),
    .op     (ctrl.op),
    .res    (wideRes)
  );

  shiftLane #(.W(HALF_W)) narrowLane (
    .srcVal (srcOp[HALF_W-1:0]),
    .amt    (amtOp[AMT_W-2:0]),
    .op     (ctrl.op),
    .res    (narrowRes)
  );

  assign result = ctrl.wide ? wideRes : {{(DATA_W-HALF_W){1'b0}}, narrowRes};

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      noMatch  <= 1'b0;
      wrIdx    <= '0;
      wrData   <= '0;
    end else begin
      outValid <= ctrl.fire;
      wrEn     <= ctrl.fire && ctrl.match && ctrl.dstWritable;
      noMatch  <= ctrl.fire && !ctrl.match;
      if (ctrl.fire && ctrl.match) begin
        wrIdx  <= ctrl.dstIdx;
        wrData <= result;
      end
    end
  end
endmodule

// File: rtl/varShiftUnit.sv
module varShiftUnit
  import varShiftPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [31:0]       instrWord,
  output logic [IDX_W-1:0]  srcIdx,
  output logic [IDX_W-1:0]  amtIdx,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] amtData,
  output logic              outValid,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              noMatch
);
  ctrlStrobe_t ctrl;

  shiftCtrl #(.IDX_W(IDX_W)) ctrlUnit (
    .inValid   (inValid),
    .instrWord (instrWord),
    .srcIdx    (srcIdx),
    .amtIdx    (amtIdx),
    .ctrl      (ctrl)
  );

  shiftDatapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) dataUnit (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .srcData  (srcData),
    .amtData  (amtData),
    .outValid (outValid),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .noMatch  (noMatch)
  );
endmodule

// File: rtl/varShiftChecker.sv
module varShiftChecker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [31:0] instrWord,
  input logic [4:0]  amtIdx,
  input logic [4:0]  srcIdx,
  input logic [63:0] srcData,
  input logic [63:0] amtData,
  input logic        outValid,
  input logic        wrEn,
  input logic [4:0]  wrIdx,
  input logic [63:0] wrData,
  input logic        noMatch
);
  logic inGroup;
  logic zeroRotate;
  assign inGroup = (instrWord[30:21] == 10'b0011010110) && (instrWord[15:12] == 4'b0010);
  assign zeroRotate = inGroup && (instrWord[11:10] == 2'b11) && (srcIdx != 5'd31) &&
                      ((amtIdx == 5'd31) ||
                       (instrWord[31] ? (amtData[5:0] == 6'd0) : (amtData[4:0] == 5'd0)));

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !wrEn && !noMatch));
  assert_nomatch_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && noMatch));
  assert_nomatch_flag_R1: assert property (@(posedge clk) disable iff (rst)
    (inValid && !inGroup) |=> (noMatch && !wrEn));
  assert_zero_dest_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (wrIdx != 5'd31));
  assert_narrow_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inGroup && !instrWord[31]) |=> (wrData[63:32] == 32'd0));
  assert_rotate_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && zeroRotate) |=>
      (wrData == ($past(instrWord[31]) ? $past(srcData) : {32'd0, $past(srcData[31:0])})));
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (!outValid && !wrEn && !noMatch));
endmodule

bind varShiftUnit varShiftChecker chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .instrWord (instrWord),
  .amtIdx    (amtIdx),
  .srcIdx    (srcIdx),
  .srcData   (srcData),
  .amtData   (amtData),
  .outValid  (outValid),
  .wrEn      (wrEn),
  .wrIdx     (wrIdx),
  .wrData    (wrData),
  .noMatch   (noMatch)
);

// File: tb/tb_varShiftUnit.sv
`timescale 1ns/1ps
module tb_varShiftUnit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = 32'd0;
  logic [4:0]  srcIdx, amtIdx, wrIdx;
  logic [63:0] srcData, amtData, wrData;
  logic        outValid, wrEn, noMatch;
  logic [63:0] rf [32];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign srcData = rf[srcIdx];
  assign amtData = rf[amtIdx];

  varShiftUnit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .srcIdx(srcIdx), .amtIdx(amtIdx), .srcData(srcData), .amtData(amtData),
    .outValid(outValid), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .noMatch(noMatch)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(bit wide, logic [1:0] op, logic [4:0] a, logic [4:0] s, logic [4:0] d);
    return {wide, 10'b0011010110, a, 4'b0010, op, s, d};
  endfunction

  function automatic logic [63:0] refResult(logic [31:0] iw, logic [63:0] a, logic [63:0] b);
    logic [127:0] dbl;
    logic [63:0]  dbl32, r;
    logic [31:0]  s32, r32;
    int amt;
    if (iw[31]) begin
      amt = int'(b[5:0]);
      case (iw[11:10])
        2'b00: r = a << amt;
        2'b01: r = a >> amt;
        2'b10: r = (a >> amt) | (a[63] ? ~({64{1'b1}} >> amt) : 64'd0);
        default: begin dbl = {a, a} >> amt; r = dbl[63:0]; end
      endcase
    end else begin
      amt = int'(b[4:0]);
      s32 = a[31:0];
      case (iw[11:10])
        2'b00: r32 = s32 << amt;
        2'b01: r32 = s32 >> amt;
        2'b10: r32 = (s32 >> amt) | (s32[31] ? ~({32{1'b1}} >> amt) : 32'd0);
        default: begin dbl32 = {s32, s32} >> amt; r32 = dbl32[31:0]; end
      endcase
      r = {32'd0, r32};
    end
    return r;
  endfunction

  task automatic runOp(input logic [31:0] iw, input string req);
    logic [63:0] sv, av, expData;
    bit grp;
    @(negedge clk);
    instrWord = iw;
    inValid = 1'b1;
    #1;
    check(srcIdx == iw[9:5], "R2 srcIdx", 64'(srcIdx), 64'(iw[9:5]));
    check(amtIdx == iw[20:16], "R2 amtIdx", 64'(amtIdx), 64'(iw[20:16]));
    sv = (iw[9:5] == 5'd31) ? 64'd0 : rf[iw[9:5]];
    av = (iw[20:16] == 5'd31) ? 64'd0 : rf[iw[20:16]];
    expData = refResult(iw, sv, av);
    grp = (iw[30:21] == 10'b0011010110) && (iw[15:12] == 4'b0010);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R11 outValid", 64'(outValid), 64'd1);
    if (grp) begin
      check(noMatch == 1'b0, {req, " R1 noMatch"}, 64'(noMatch), 64'd0);
      check(wrEn == (iw[4:0] != 5'd31), {req, " R10 wrEn"}, 64'(wrEn), 64'(iw[4:0] != 5'd31));
      check(wrIdx == iw[4:0], {req, " R2 wrIdx"}, 64'(wrIdx), 64'(iw[4:0]));
      check(wrData == expData, {req, " wrData"}, wrData, expData);
    end else begin
      check(noMatch == 1'b1, "R1 noMatch", 64'(noMatch), 64'd1);
      check(wrEn == 1'b0, "R1 wrEn", 64'(wrEn), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf[i] = {$urandom, $urandom};
    rf[31] = 64'hDEAD_BEEF_CAFE_F00D;
    repeat (3) @(negedge clk);
    check(!outValid && !wrEn && !noMatch, "R12 reset state", {61'd0, outValid, wrEn, noMatch}, 64'd0);
    rst = 1'b0;

    rf[1] = 64'h8123_4567_89AB_CDEF;
    rf[2] = 64'd67;
    rf[3] = 64'hFFFF_FFFF_0000_0025;
    rf[4] = 64'd64;
    rf[5] = 64'd32;
    rf[6] = 64'hFFFF_FFFF_7000_0000;
    rf[7] = 64'h0000_0000_8000_0010;
    rf[8] = 64'd4;

    // R3 each operation, 64-bit
    runOp(mkWord(1, 2'b00, 5'd8, 5'd1, 5'd10), "R3 lsl");
    runOp(mkWord(1, 2'b01, 5'd8, 5'd1, 5'd10), "R3 lsr");
    runOp(mkWord(1, 2'b10, 5'd8, 5'd1, 5'd10), "R6 asr64");
    runOp(mkWord(1, 2'b11, 5'd8, 5'd1, 5'd10), "R7 ror64");
    // R4 32-bit mode with garbage upper source
    runOp(mkWord(0, 2'b00, 5'd8, 5'd1, 5'd11), "R4 lsl32");
    runOp(mkWord(0, 2'b11, 5'd8, 5'd1, 5'd11), "R7 ror32");
    // R5 amount wrap
    runOp(mkWord(1, 2'b01, 5'd2, 5'd1, 5'd12), "R5 wrap64");
    runOp(mkWord(0, 2'b00, 5'd3, 5'd1, 5'd12), "R5 wrap32");
    // R6 fill bits in 32-bit mode
    runOp(mkWord(0, 2'b10, 5'd8, 5'd7, 5'd13), "R6 asr32 neg");
    runOp(mkWord(0, 2'b10, 5'd8, 5'd6, 5'd13), "R6 asr32 pos");
    // R8 rotate by zero after masking
    runOp(mkWord(1, 2'b11, 5'd4, 5'd1, 5'd14), "R8 ror64 zero");
    runOp(mkWord(0, 2'b11, 5'd5, 5'd1, 5'd14), "R8 ror32 zero");
    // R9 zero register reads
    runOp(mkWord(1, 2'b01, 5'd8, 5'd31, 5'd15), "R9 src zero");
    runOp(mkWord(1, 2'b11, 5'd31, 5'd1, 5'd15), "R9 amt zero");
    // R10 destination 31 dropped
    runOp(mkWord(1, 2'b00, 5'd8, 5'd1, 5'd31), "R10 dst31");
    // R1 non-matching words
    runOp(mkWord(1, 2'b00, 5'd8, 5'd1, 5'd10) ^ 32'h0200_0000, "R1 hi");
    runOp(mkWord(0, 2'b00, 5'd8, 5'd1, 5'd10) ^ 32'h0000_1000, "R1 mid");
    // R11 nothing follows an empty cycle
    @(negedge clk);
    check(!outValid && !noMatch && !wrEn, "R11 idle", {61'd0, outValid, wrEn, noMatch}, 64'd0);

    // R12 reset while a word is strobed
    @(negedge clk);
    instrWord = mkWord(1, 2'b00, 5'd8, 5'd1, 5'd10);
    inValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b0;
    check(!outValid && !wrEn && !noMatch, "R12 mid reset", {61'd0, outValid, wrEn, noMatch}, 64'd0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      if (n % 16 == 0) begin
        for (int i = 0; i < 31; i++) begin
          case ($urandom % 4)
            0: rf[i] = 64'($urandom % 130);
            1: rf[i] = {$urandom, $urandom} | 64'h8000_0000_8000_0000;
            default: rf[i] = {$urandom, $urandom};
          endcase
        end
      end
      w = mkWord(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
      if ($urandom % 8 == 0) w = w ^ (32'h1 << (12 + ($urandom % 4)));
      runOp(w, "R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule